// File: doc/BRIEF.md
# Burst-of-Four Common-I/O Memory Sequencer

This block sequences commands for a memory whose single data bus carries traffic in both directions and which always moves data in groups of four beats. A command is sampled from an active-low load strobe, a read/write select and a word address. Once a command is taken, the block steps through four beats that cannot be interrupted. On each beat it produces the internal array address, and during writes it also produces a write strobe with a per-lane byte mask. A small behavioural storage array sits inside, so that reads return real data. Read data leaves through a pipeline of fixed depth, together with an output-enable that a pad ring uses to drive the shared bus. Write data is late: it arrives on the beat cycles after the write command, not with it.

One clock, the beat clock, stands for successive data edges. Because a burst holds four beats, a new command can be taken no sooner than on the last beat of the burst before it. That gives gapless back-to-back bursts, or one command every other command period. A load seen while beats 0 to 2 of a burst are still running is a protocol error: it is flagged and otherwise ignored. When no load arrives by the last beat, the sequencer deselects. A deselect waits behind any read data still in the pipeline, so the output-enable drops only after the fourth read beat has left. The data width is 9, 18 or 36 bits, set at compile time, with one byte-write lane per 9 bits. In the 9-bit setting the two low address bits are not inputs and every burst starts at offset 00.

The control state machine has three states:
- IDLE: the deselect state.
- READ: a read burst is active.
- WRITE: a write burst is active.

Its transitions are as follows:
- IDLE goes to READ or WRITE when a load is seen; otherwise it stays in IDLE.
- READ or WRITE stays in its own state on beats 0 to 2, and the beat counter advances.
- On beat 3, READ or WRITE goes to READ or WRITE for a chained load, or to IDLE when no load is seen (deselect).

Top module: `quad_burst_seq`

## Requirements
- R1: Every accepted command runs exactly four consecutive beat cycles, numbered 0 to 3, in the same state. It starts on the cycle after the clock edge that sampled `load_n` low.
- R2: A `load_n` low sampled on beats 0, 1 or 2 of a running burst is ignored. The burst goes on unchanged, no read output is started, and `proto_err` is high for the one following cycle.
- R3: In the 18-bit and 36-bit settings, `beat_addr[1:0]` on beat k equals (`addr[1:0]` + k) mod 4, wrapping from 11 to 00. `beat_addr` above bit 1 equals `addr` above bit 1.
- R4: In the 9-bit setting, `beat_addr` is {`addr`, k} on beat k, so the low bits run 00, 01, 10, 11.
- R5: `wr_stb` is high on exactly the four beats of a write. The data word on `dq_in` during beat k is stored at that beat's `beat_addr`.
- R6: `bwe_n[j]` low during a write beat sets `wr_mask[j]` and writes lane j, which is data bits 9j to 9j+8. When `bwe_n[j]` is high, that lane of the word keeps its old value.
- R7: For a read, `dq_oe` is high for exactly the four cycles beginning RD_LAT cycles after beat 0. In those cycles `dq_out` carries the stored words of beats 0 to 3, in order.
- R8: When no load is sampled on beat 3, the block deselects. `wr_stb` falls, and `dq_oe` goes low in the cycle after the last read data cycle.
- R9: A read chained on beat 3 of a write to the same word returns the newly written, lane-masked data.
- R10: While reset is asserted and just after it is released, `dq_oe`, `wr_stb`, `wr_mask` and `proto_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low command load strobe |
| rd_sel | input | 1 | 1 = read, 0 = write; sampled with a load |
| addr | input | INDEX_W or INDEX_W-2 | External word address (2 bits shorter in the 9-bit setting) |
| bwe_n | input | DQ_W/9 | Active-low byte-lane write enables, one per beat |
| dq_in | input | DQ_W | Write data from the bus, one word per write beat |
| dq_out | output | DQ_W | Read data toward the bus |
| dq_oe | output | 1 | Bus output-enable for read data |
| beat_addr | output | INDEX_W | Internal array address of the current beat |
| wr_stb | output | 1 | Array write strobe |
| wr_mask | output | DQ_W/9 | Lanes written on this beat |
| proto_err | output | 1 | One-cycle flag for an ignored mid-burst load |

## Verification
Two functions can fall in the same cycle. The first is the array write of a burst's last write beat. The second is a chained read command taken at that same edge, whose beat 0 reads the word being written. The bench provokes this by holding the load low on beat 3 of writes whose read addresses the same word group, for every byte-mask pattern. It then judges the result against lane-merged data computed in the bench. A second collision is a mid-burst load arriving while write beats run. The bench places it on beats 0, 1 and 2 in turn and checks three things: the flag, the continuing address sequence, and a read-back showing the write was not disturbed.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

    localparam int LANE_W    = 9;
    localparam int BURST_LEN = 4;
endpackage

// File: rtl/qbs_fsm.sv
module qbs_fsm
    import qbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_n,
    input  logic       rd_sel,
    output seq_state_t st,
    output logic [1:0] beat,
    output logic       accept,
    output logic       rd_beat,
    output logic       wr_beat,
    output logic       proto_err
);
    seq_state_t st_q, st_d;
    logic [1:0] beat_q, beat_d;
    logic       err_q, err_d;
    logic       at_edge;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            beat_q <= 2'd0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            beat_q <= beat_d;
            err_q  <= err_d;
        end
    end

    // next state
    always_comb begin
        at_edge = (st_q == ST_IDLE) || (beat_q == 2'(BURST_LEN - 1));
        accept  = !load_n && at_edge;
        err_d   = !load_n && !at_edge;
        st_d    = st_q;
        beat_d  = beat_q;
        unique case (st_q)
            ST_IDLE: begin
                beat_d = 2'd0;
                if (accept) st_d = rd_sel ? ST_READ : ST_WRITE;
            end
            ST_READ, ST_WRITE: begin
                if (!at_edge) begin
                    beat_d = beat_q + 2'd1;
                end else if (accept) begin
                    st_d   = rd_sel ? ST_READ : ST_WRITE;
                    beat_d = 2'd0;
                end else begin
                    st_d   = ST_IDLE;
                    beat_d = 2'd0;
                end
            end
            default: begin
                st_d   = ST_IDLE;
                beat_d = 2'd0;
            end
        endcase
    end

    // outputs
    always_comb begin
        st        = st_q;
        beat      = beat_q;
        rd_beat   = (st_q == ST_READ);
        wr_beat   = (st_q == ST_WRITE);
        proto_err = err_q;
    end
endmodule

// File: rtl/qbs_addr_gen.sv
module qbs_addr_gen #(
    parameter int INDEX_W = 6,
    parameter int NARROW  = 0,
    parameter int EXT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [EXT_W-1:0]   addr,
    input  logic [1:0]         beat,
    output logic [INDEX_W-1:0] beat_addr
);
    localparam int HI_W = INDEX_W - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      lo_q;
    logic [1:0]      lo_start;

    generate
        if (NARROW != 0) begin : g_narrow
            assign lo_start = 2'b00;
        end else begin : g_wide
            assign lo_start = addr[1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= 2'b00;
        end else if (accept) begin
            hi_q <= addr[EXT_W-1:EXT_W-HI_W];
            lo_q <= lo_start;
        end
    end

    assign beat_addr = {hi_q, 2'(lo_q + beat)};
endmodule

// File: rtl/qbs_mem.sv
module qbs_mem #(
    parameter int INDEX_W = 6,
    parameter int DQ_W    = 36,
    parameter int LANES   = 4
) (
    input  logic               clk,
    input  logic               we,
    input  logic [LANES-1:0]   lane_en,
    input  logic [INDEX_W-1:0] waddr,
    input  logic [DQ_W-1:0]    wdata,
    input  logic [INDEX_W-1:0] raddr,
    output logic [DQ_W-1:0]    rdata
);
    localparam int DEPTH = 1 << INDEX_W;
    localparam int LW    = qbs_pkg::LANE_W;

    logic [DQ_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int j = 0; j < LANES; j++) begin
                if (lane_en[j]) cells[waddr][j*LW +: LW] <= wdata[j*LW +: LW];
            end
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/qbs_rd_pipe.sv
module qbs_rd_pipe #(
    parameter int DQ_W   = 36,
    parameter int RD_LAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [DQ_W-1:0] in_data,
    output logic            out_vld,
    output logic [DQ_W-1:0] out_data
);
    logic [RD_LAT-1:0] vld_q;
    logic [DQ_W-1:0]   dat_q [RD_LAT];

    generate
        for (genvar i = 0; i < RD_LAT; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vld_q[0] <= 1'b0;
                        dat_q[0] <= '0;
                    end else begin
                        vld_q[0] <= in_vld;
                        dat_q[0] <= in_vld ? in_data : '0;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vld_q[i] <= 1'b0;
                        dat_q[i] <= '0;
                    end else begin
                        vld_q[i] <= vld_q[i-1];
                        dat_q[i] <= dat_q[i-1];
                    end
                end
            end
        end
    endgenerate

    assign out_vld  = vld_q[RD_LAT-1];
    assign out_data = dat_q[RD_LAT-1];
endmodule

// File: rtl/quad_burst_seq.sv
module quad_burst_seq
    import qbs_pkg::*;
#(
    parameter int DQ_W    = 36,
    parameter int INDEX_W = 6,
    parameter int RD_LAT  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   load_n,
    input  logic                                   rd_sel,
    input  logic [INDEX_W-((DQ_W==9)?2:0)-1:0]     addr,
    input  logic [DQ_W/9-1:0]                      bwe_n,
    input  logic [DQ_W-1:0]                        dq_in,
    output logic [DQ_W-1:0]                        dq_out,
    output logic                                   dq_oe,
    output logic [INDEX_W-1:0]                     beat_addr,
    output logic                                   wr_stb,
    output logic [DQ_W/9-1:0]                      wr_mask,
    output logic                                   proto_err
);
    localparam int LANES  = DQ_W / LANE_W;
    localparam int NARROW = (DQ_W == 9) ? 1 : 0;
    localparam int EXT_W  = INDEX_W - ((NARROW != 0) ? 2 : 0);

    seq_state_t      st;
    logic [1:0]      beat;
    logic            accept;
    logic            rd_beat;
    logic            wr_beat;
    logic [DQ_W-1:0] arr_rdata;

    qbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .rd_sel    (rd_sel),
        .st        (st),
        .beat      (beat),
        .accept    (accept),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat),
        .proto_err (proto_err)
    );

    qbs_addr_gen #(
        .INDEX_W (INDEX_W),
        .NARROW  (NARROW),
        .EXT_W   (EXT_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .addr      (addr),
        .beat      (beat),
        .beat_addr (beat_addr)
    );

    assign wr_stb  = wr_beat;
    assign wr_mask = wr_beat ? ~bwe_n : '0;

    qbs_mem #(
        .INDEX_W (INDEX_W),
        .DQ_W    (DQ_W),
        .LANES   (LANES)
    ) u_mem (
        .clk     (clk),
        .we      (wr_beat),
        .lane_en (wr_mask),
        .waddr   (beat_addr),
        .wdata   (dq_in),
        .raddr   (beat_addr),
        .rdata   (arr_rdata)
    );

    qbs_rd_pipe #(
        .DQ_W   (DQ_W),
        .RD_LAT (RD_LAT)
    ) u_rdp (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rd_beat),
        .in_data  (arr_rdata),
        .out_vld  (dq_oe),
        .out_data (dq_out)
    );
endmodule

// File: rtl/quad_burst_seq_chk.sv
module quad_burst_seq_chk
    import qbs_pkg::*;
#(
    parameter int INDEX_W = 6,
    parameter int NARROW  = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_n,
    input seq_state_t         st,
    input logic [1:0]         beat,
    input logic [INDEX_W-1:0] beat_addr,
    input logic               proto_err,
    input logic               dq_oe
);
    logic [7:0] oe_run_q;
    logic       mid_burst;

    assign mid_burst = (st != ST_IDLE) && (beat != 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_run_q <= 8'd0;
        else        oe_run_q <= dq_oe ? oe_run_q + 8'd1 : 8'd0;
    end

    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mid_burst |=> (st == $past(st)) && (beat == $past(beat) + 2'd1)); // R1

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        mid_burst |=> (beat_addr[1:0] == $past(beat_addr[1:0]) + 2'd1)
                   && (beat_addr[INDEX_W-1:2] == $past(beat_addr[INDEX_W-1:2]))); // R3

    AST_ERR_MIDBURST: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(mid_burst && !load_n)); // R2

    AST_OE_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> (oe_run_q[1:0] == 2'd0)); // R7

    generate
        if (NARROW != 0) begin : g_nar
            AST_NARROW_START: assert property (@(posedge clk) disable iff (!rst_n)
                ((st != ST_IDLE) && (beat == 2'd0)) |-> (beat_addr[1:0] == 2'b00)); // R4
        end
    endgenerate
endmodule

bind quad_burst_seq quad_burst_seq_chk #(
    .INDEX_W (INDEX_W),
    .NARROW  (NARROW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .st        (st),
    .beat      (beat),
    .beat_addr (beat_addr),
    .proto_err (proto_err),
    .dq_oe     (dq_oe)
);

// File: tb/quad_burst_seq_tb_top.sv
module quad_burst_seq_tb_top;
    localparam int RL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // wide instance (x36, 64 words)
    logic        load_n = 1'b1, rd_sel = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  bwe_n = 4'hF;
    logic [35:0] dq_in = '0, dq_out;
    logic        dq_oe, wr_stb, proto_err;
    logic [5:0]  beat_addr;
    logic [3:0]  wr_mask;

    // narrow instance (x9, 64 words, 4-bit external address)
    logic        n_load_n = 1'b1, n_rd_sel = 1'b0;
    logic [3:0]  n_addr = '0;
    logic [0:0]  n_bwe_n = 1'b1;
    logic [8:0]  n_dq_in = '0, n_dq_out;
    logic        n_dq_oe, n_wr_stb, n_proto_err;
    logic [5:0]  n_beat_addr;
    logic [0:0]  n_wr_mask;

    quad_burst_seq #(.DQ_W(36), .INDEX_W(6), .RD_LAT(RL)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_sel(rd_sel), .addr(addr),
        .bwe_n(bwe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .beat_addr(beat_addr), .wr_stb(wr_stb), .wr_mask(wr_mask), .proto_err(proto_err));

    quad_burst_seq #(.DQ_W(9), .INDEX_W(6), .RD_LAT(RL)) dut_n_i (
        .clk(clk), .rst_n(rst_n), .load_n(n_load_n), .rd_sel(n_rd_sel), .addr(n_addr),
        .bwe_n(n_bwe_n), .dq_in(n_dq_in), .dq_out(n_dq_out), .dq_oe(n_dq_oe),
        .beat_addr(n_beat_addr), .wr_stb(n_wr_stb), .wr_mask(n_wr_mask), .proto_err(n_proto_err));

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [35:0] wm [64];
    logic [8:0]  nm [64];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [35:0] wdat(input int a, input int k, input int s);
        return 36'(a * 36'h1_0203 + k * 36'h5_5011 + s * 36'h9_1357 + 36'h3);
    endfunction

    function automatic logic [5:0] wba(input int a, input int k);
        return {6'(a) >> 2, 2'(a + k)};
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] m);
        logic [35:0] r = old;
        for (int j = 0; j < 4; j++) if (m[j]) r[j*9 +: 9] = nw[j*9 +: 9];
        return r;
    endfunction

    // write burst; err_beat >= 0 injects a load on that beat; chain launches a read of ca on beat 3
    task automatic wr_wide(input int a, input int s, input logic [3:0] m,
                           input int err_beat, input bit chain, input int ca);
        logic [5:0] ba;
        load_n = 1'b0; rd_sel = 1'b0; addr = 6'(a);
        tick();
        load_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            ba = wba(a, k);
            dq_in = wdat(a, k, s);
            bwe_n = ~m;
            if (k == err_beat) begin load_n = 1'b0; rd_sel = 1'b1; addr = 6'(a ^ 1); end
            if (k == err_beat + 1) load_n = 1'b1;
            if (k == 3 && chain) begin load_n = 1'b0; rd_sel = 1'b1; addr = 6'(ca); end
            #1;
            chk(wr_stb == 1'b1, "R5", "wr_stb in write beat", 64'(wr_stb), 64'd1);
            chk(beat_addr == ba, "R3", "write beat_addr", 64'(beat_addr), 64'(ba));
            chk(wr_mask == m, "R6", "wr_mask", 64'(wr_mask), 64'(m));
            if (err_beat >= 0 && k == err_beat + 1) begin
                chk(proto_err == 1'b1, "R2", "proto_err after mid-burst load", 64'(proto_err), 64'd1);
                chk(dq_oe == 1'b0, "R2", "no read launched", 64'(dq_oe), 64'd0);
            end else begin
                chk(proto_err == 1'b0, "R2", "proto_err quiet", 64'(proto_err), 64'd0);
            end
            wm[ba] = merge(wm[ba], dq_in, m);
            tick();
        end
        bwe_n = 4'hF;
        if (!chain) begin
            load_n = 1'b1;
            chk(wr_stb == 1'b0, "R8", "deselect after write", 64'(wr_stb), 64'd0);
            chk(dq_oe == 1'b0, "R2", "no read output after ignored load", 64'(dq_oe), 64'd0);
        end
    endtask

    task automatic rd_wide(input int a, input bit issued, input string req);
        logic [5:0] ba;
        bit eoe;
        if (!issued) begin
            load_n = 1'b0; rd_sel = 1'b1; addr = 6'(a);
            tick();
        end
        load_n = 1'b1;
        for (int i = 0; i <= RL + 4; i++) begin
            if (i < 4) begin
                ba = wba(a, i);
                chk(beat_addr == ba, "R3", "read beat_addr", 64'(beat_addr), 64'(ba));
                chk(wr_stb == 1'b0, "R5", "no wr_stb in read", 64'(wr_stb), 64'd0);
            end
            eoe = (i >= RL) && (i < RL + 4);
            chk(dq_oe == eoe, (i == RL + 4) ? "R8" : "R7", "dq_oe window", 64'(dq_oe), 64'(eoe));
            if (eoe) begin
                ba = wba(a, i - RL);
                chk(dq_out == wm[ba], req, "read data", 64'(dq_out), 64'(wm[ba]));
            end
            tick();
        end
    endtask

    task automatic wr_nar(input int a, input int s);
        logic [5:0] ba;
        n_load_n = 1'b0; n_rd_sel = 1'b0; n_addr = 4'(a);
        tick();
        n_load_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            ba = {4'(a), 2'(k)};
            n_dq_in = 9'(a * 37 + k * 11 + s);
            n_bwe_n = 1'b0;
            #1;
            chk(n_beat_addr == ba, "R4", "narrow write beat_addr", 64'(n_beat_addr), 64'(ba));
            chk(n_wr_stb == 1'b1, "R5", "narrow wr_stb", 64'(n_wr_stb), 64'd1);
            nm[ba] = n_dq_in;
            tick();
        end
        n_bwe_n = 1'b1;
    endtask

    task automatic rd_nar(input int a);
        logic [5:0] ba;
        bit eoe;
        n_load_n = 1'b0; n_rd_sel = 1'b1; n_addr = 4'(a);
        tick();
        n_load_n = 1'b1;
        for (int i = 0; i <= RL + 4; i++) begin
            if (i < 4) begin
                ba = {4'(a), 2'(i)};
                chk(n_beat_addr == ba, "R4", "narrow read beat_addr", 64'(n_beat_addr), 64'(ba));
            end
            eoe = (i >= RL) && (i < RL + 4);
            chk(n_dq_oe == eoe, "R7", "narrow dq_oe", 64'(n_dq_oe), 64'(eoe));
            if (eoe) begin
                ba = {4'(a), 2'(i - RL)};
                chk(n_dq_out == nm[ba], "R7", "narrow read data", 64'(n_dq_out), 64'(nm[ba]));
            end
            tick();
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin wm[i] = '0; nm[i] = '0; end
        repeat (3) tick();
        chk(dq_oe == 1'b0 && wr_stb == 1'b0, "R10", "outputs in reset",
            64'({dq_oe, wr_stb}), 64'd0);
        rst_n = 1'b1;
        tick();
        chk({dq_oe, wr_stb, wr_mask, proto_err} == '0, "R10", "outputs after reset",
            64'({dq_oe, wr_stb, wr_mask, proto_err}), 64'd0);

        // R1 R3 R5: full sweep of start addresses, every start offset
        for (int a = 0; a < 64; a++) wr_wide(a, 1, 4'hF, -1, 1'b0, 0);
        for (int a = 0; a < 64; a++) rd_wide(a, 1'b0, "R5");

        // R6: every byte-mask pattern
        for (int m = 0; m < 16; m++) begin
            wr_wide(9, m + 2, 4'(m), -1, 1'b0, 0);
            rd_wide(9, 1'b0, "R6");
        end

        // R9: chained write->read to the same words, all masks
        for (int m = 0; m < 16; m++) begin
            wr_wide(40 + (m % 4), m + 30, 4'(m), -1, 1'b1, 40 + (m % 4));
            rd_wide(40 + (m % 4), 1'b1, "R9");
        end

        // R2: ignored load on beats 0, 1, 2
        for (int e = 0; e < 3; e++) begin
            wr_wide(20 + e, 50 + e, 4'hF, e, 1'b0, 0);
            rd_wide(20 + e, 1'b0, "R2");
        end

        // R4: narrow configuration sweep
        for (int a = 0; a < 16; a++) wr_nar(a, 5);
        for (int a = 0; a < 16; a++) rd_nar(a);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule